// File: doc/BRIEF.md
# Programmable Array Output Cell with Asynchronous Register

This block is a single output cell of a sum-of-products logic array. The AND plane sits outside the block, and its results arrive here as plain product-term bits. The cell ORs its own data terms into one data value. That value either goes straight to the pin or is first held in a storage register. The register's clock, set and reset each come from their own product term, so none of them is tied to a system clock.

Two static configuration bits choose how the cell behaves. One selects the combinational bypass and the other inverts the output. A shared active-low preload line writes the pin-side input value into the register, which lets a test force an arbitrary state. A power-on reset input clears the register.

The output driver is enabled only by the AND of the cell's enable term and a shared external enable line. The feedback to the array takes its value from the pin side. When the cell drives, feedback is the value being driven. When the cell is used as an input, feedback is the external pin value. Routing register state back this way lets several cells form a state machine.

Top module: `pla_out_macrocell`

## Requirements
- R1: The data value is the OR of all NUM_DT data terms. In registered mode (cfg_bypass_i=0) the register loads that value on each rising edge of clk_term_i while por_i=0, preload_n_i=1, rst_term_i=0 and set_term_i=0.
- R2: With cfg_bypass_i=1 the register is bypassed and pin_out_o follows the data OR at once, with no clock-term edge needed. In this mode the set and reset terms are held high.
- R3: cfg_invert_i=1 inverts the selected value (register or bypass) on its way to pin_out_o, and cfg_invert_i=0 passes it unchanged. A change of cfg_invert_i alone flips pin_out_o without touching the stored state.
- R4: pin_oe_o is 1 only when oe_term_i=1 and ext_oe_n_i=0. The external line enables at logic 0.
- R5: fb_o equals pin_out_o while pin_oe_o=1 and equals pin_in_i while pin_oe_o=0. This lets registered cells build a state machine whose next state depends on its present state.
- R6: A rising rst_term_i clears the register and a rising set_term_i sets it, both without a clock-term edge. If both terms are high, the register goes to 0. While rst_term_i is high, clock-term edges leave the register at 0. A set term that is high at a clock-term edge wins over the data value.
- R7: While preload_n_i=0, the register takes pin_in_i when preload falls and at every clock-term edge. Preload wins over reset, set and clock. After preload_n_i returns high, the register keeps the preloaded value until the next clock, set or reset event.
- R8: While por_i=1 the register is 0 and overrides preload. pin_out_o therefore reads 0 with cfg_invert_i=0 and 1 with cfg_invert_i=1.
- R9: In registered mode, changes of the data terms without a clock-term edge leave pin_out_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_i | input | 1 | Power-on reset, active high, clears the register |
| data_terms_i | input | NUM_DT | Data product terms, ORed together |
| clk_term_i | input | 1 | Register clock product term, rising edge active |
| set_term_i | input | 1 | Asynchronous set product term |
| rst_term_i | input | 1 | Asynchronous reset product term |
| oe_term_i | input | 1 | Output-enable product term |
| ext_oe_n_i | input | 1 | Shared external output enable, active low |
| preload_n_i | input | 1 | Shared preload strobe, active low |
| pin_in_i | input | 1 | Pin-side input value (preload source, input-mode feedback) |
| cfg_bypass_i | input | 1 | Static: 1 selects combinational bypass |
| cfg_invert_i | input | 1 | Static: 1 selects inverted output |
| pin_out_o | output | 1 | Value driven onto the pin |
| pin_oe_o | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback value to the array |

## Verification
The output stage after the register is purely combinational, so a wrong register value shows on pin_out_o as soon as the event that wrote it settles. That event can be a clock-term edge, a set or reset edge, or a preload fall. A wrong priority among these events gives the wrong level on the pin within the same step. A feedback or enable error may not show on the pin at all. It shows one clock-term edge later in a two-cell counter, whose count then leaves the 0,1,2,3 cycle.

// File: rtl/pla_cell_pkg.sv
package pla_cell_pkg;

    // Stored state of one cell register.
    typedef struct packed {
        logic q;
    } cell_state_t;

    // Static per-cell mode bits.
    typedef struct packed {
        logic bypass;
        logic invert;
    } cell_mode_t;

endpackage

// File: rtl/pla_sop_sum.sv
module pla_sop_sum #(
    parameter int NUM_TERMS = 4
) (
    input  logic [NUM_TERMS-1:0] terms_i,
    output logic                 sum_o
);

    localparam int CHAIN_W = NUM_TERMS + 1;

    logic [CHAIN_W-1:0] chain;

    assign chain[0] = 1'b0;

    for (genvar g = 0; g < NUM_TERMS; g++) begin : g_or
        assign chain[g+1] = chain[g] | terms_i[g];
    end

    assign sum_o = chain[CHAIN_W-1];

endmodule

// File: rtl/pla_async_reg.sv
module pla_async_reg
    import pla_cell_pkg::*;
(
    input  logic clk_term_i,
    input  logic por_i,
    input  logic preload_n_i,
    input  logic load_val_i,
    input  logic rst_term_i,
    input  logic set_term_i,
    input  logic data_i,
    output logic q_o
);

    cell_state_t state_d;
    cell_state_t state_q;

    // Next value on a clock-term edge: the data sum.
    always_comb begin
        state_d   = state_q;
        state_d.q = data_i;
    end

    // Priority: power-on reset, preload, reset term, set term, clock term.
    always_ff @(posedge clk_term_i or posedge por_i or negedge preload_n_i
                or posedge rst_term_i or posedge set_term_i) begin
        if (por_i) begin
            state_q <= '0;
        end else if (!preload_n_i) begin
            state_q.q <= load_val_i;
        end else if (rst_term_i) begin
            state_q.q <= 1'b0;
        end else if (set_term_i) begin
            state_q.q <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign q_o = state_q.q;

endmodule

// File: rtl/pla_out_stage.sv
module pla_out_stage
    import pla_cell_pkg::*;
(
    input  cell_mode_t mode_i,
    input  logic       sum_i,
    input  logic       q_i,
    input  logic       oe_term_i,
    input  logic       ext_oe_n_i,
    input  logic       pin_in_i,
    output logic       drive_o,
    output logic       drive_en_o,
    output logic       fb_o
);

    logic selected;

    always_comb begin
        selected   = mode_i.bypass ? sum_i : q_i;
        drive_o    = selected ^ mode_i.invert;
        drive_en_o = oe_term_i & ~ext_oe_n_i;
        fb_o       = drive_en_o ? drive_o : pin_in_i;
    end

endmodule

// File: rtl/pla_out_macrocell.sv
module pla_out_macrocell
    import pla_cell_pkg::*;
#(
    parameter int NUM_DT = 4
) (
    input  logic              por_i,
    input  logic [NUM_DT-1:0] data_terms_i,
    input  logic              clk_term_i,
    input  logic              set_term_i,
    input  logic              rst_term_i,
    input  logic              oe_term_i,
    input  logic              ext_oe_n_i,
    input  logic              preload_n_i,
    input  logic              pin_in_i,
    input  logic              cfg_bypass_i,
    input  logic              cfg_invert_i,
    output logic              pin_out_o,
    output logic              pin_oe_o,
    output logic              fb_o
);

    logic       data_sum;
    logic       cell_q;
    cell_mode_t mode;

    assign mode.bypass = cfg_bypass_i;
    assign mode.invert = cfg_invert_i;

    pla_sop_sum #(
        .NUM_TERMS(NUM_DT)
    ) u_sum (
        .terms_i (data_terms_i),
        .sum_o   (data_sum)
    );

    pla_async_reg u_reg (
        .clk_term_i  (clk_term_i),
        .por_i       (por_i),
        .preload_n_i (preload_n_i),
        .load_val_i  (pin_in_i),
        .rst_term_i  (rst_term_i),
        .set_term_i  (set_term_i),
        .data_i      (data_sum),
        .q_o         (cell_q)
    );

    pla_out_stage u_out (
        .mode_i     (mode),
        .sum_i      (data_sum),
        .q_i        (cell_q),
        .oe_term_i  (oe_term_i),
        .ext_oe_n_i (ext_oe_n_i),
        .pin_in_i   (pin_in_i),
        .drive_o    (pin_out_o),
        .drive_en_o (pin_oe_o),
        .fb_o       (fb_o)
    );

endmodule

// File: rtl/pla_out_macrocell_chk.sv
module pla_out_macrocell_chk #(
    parameter int NUM_DT = 4
) (
    input logic              por_i,
    input logic [NUM_DT-1:0] data_terms_i,
    input logic              clk_term_i,
    input logic              set_term_i,
    input logic              rst_term_i,
    input logic              oe_term_i,
    input logic              ext_oe_n_i,
    input logic              preload_n_i,
    input logic              pin_in_i,
    input logic              cfg_bypass_i,
    input logic              cfg_invert_i,
    input logic              pin_out_o,
    input logic              pin_oe_o,
    input logic              fb_o,
    input logic              cell_q
);

    AST_OE_GATE: assert property (@(posedge clk_term_i) disable iff (por_i)
        pin_oe_o == (oe_term_i && !ext_oe_n_i)); // R4

    AST_FB_SELECT: assert property (@(posedge clk_term_i) disable iff (por_i)
        fb_o == (pin_oe_o ? pin_out_o : pin_in_i)); // R5

    AST_BYPASS_PATH: assert property (@(posedge clk_term_i) disable iff (por_i)
        cfg_bypass_i |-> (pin_out_o == ((|data_terms_i) ^ cfg_invert_i))); // R2

    AST_REG_VIEW: assert property (@(posedge clk_term_i) disable iff (por_i)
        !cfg_bypass_i |-> (pin_out_o == (cell_q ^ cfg_invert_i))); // R3

    AST_RST_HOLD: assert property (@(negedge clk_term_i) disable iff (por_i)
        (rst_term_i && preload_n_i && $past(rst_term_i) && $past(preload_n_i))
        |-> !cell_q); // R6

    AST_PRELOAD_HOLD: assert property (@(negedge clk_term_i) disable iff (por_i)
        (!preload_n_i && $past(!preload_n_i) && (pin_in_i == $past(pin_in_i)))
        |-> (cell_q == pin_in_i)); // R7

endmodule

bind pla_out_macrocell pla_out_macrocell_chk #(.NUM_DT(NUM_DT)) u_chk (
    .por_i        (por_i),
    .data_terms_i (data_terms_i),
    .clk_term_i   (clk_term_i),
    .set_term_i   (set_term_i),
    .rst_term_i   (rst_term_i),
    .oe_term_i    (oe_term_i),
    .ext_oe_n_i   (ext_oe_n_i),
    .preload_n_i  (preload_n_i),
    .pin_in_i     (pin_in_i),
    .cfg_bypass_i (cfg_bypass_i),
    .cfg_invert_i (cfg_invert_i),
    .pin_out_o    (pin_out_o),
    .pin_oe_o     (pin_oe_o),
    .fb_o         (fb_o),
    .cell_q       (cell_q)
);

// File: tb/pla_out_macrocell_tb.sv
module pla_out_macrocell_tb;

    localparam int NUM_DT = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // Main cell under test
    logic              por = 1'b1;
    logic [NUM_DT-1:0] dt = '0;
    logic              clk_term = 1'b0;
    logic              set_t = 1'b0;
    logic              rst_t = 1'b0;
    logic              oe_t = 1'b1;
    logic              ext_oe_n = 1'b0;
    logic              preload_n = 1'b1;
    logic              pin_in = 1'b0;
    logic              bypass = 1'b0;
    logic              invert = 1'b0;
    logic              pin_out, pin_oe, fb;

    pla_out_macrocell #(.NUM_DT(NUM_DT)) u_dut (
        .por_i(por), .data_terms_i(dt), .clk_term_i(clk_term),
        .set_term_i(set_t), .rst_term_i(rst_t), .oe_term_i(oe_t),
        .ext_oe_n_i(ext_oe_n), .preload_n_i(preload_n), .pin_in_i(pin_in),
        .cfg_bypass_i(bypass), .cfg_invert_i(invert),
        .pin_out_o(pin_out), .pin_oe_o(pin_oe), .fb_o(fb)
    );

    // Two-cell counter built through the feedback path
    logic              sm_clk = 1'b0;
    logic              sm_preload_n = 1'b1;
    logic              sm_ext_oe_n = 1'b0;
    logic [1:0]        sm_pin = 2'b00;
    logic [1:0]        sm_fb;
    logic [1:0]        sm_out, sm_oe;
    logic [NUM_DT-1:0] sm_dt0, sm_dt1;

    assign sm_dt0 = {3'b000, ~sm_fb[0]};
    assign sm_dt1 = {2'b00, sm_fb[1] & ~sm_fb[0], ~sm_fb[1] & sm_fb[0]};

    pla_out_macrocell #(.NUM_DT(NUM_DT)) u_sm0 (
        .por_i(por), .data_terms_i(sm_dt0), .clk_term_i(sm_clk),
        .set_term_i(1'b0), .rst_term_i(1'b0), .oe_term_i(1'b1),
        .ext_oe_n_i(sm_ext_oe_n), .preload_n_i(sm_preload_n), .pin_in_i(sm_pin[0]),
        .cfg_bypass_i(1'b0), .cfg_invert_i(1'b0),
        .pin_out_o(sm_out[0]), .pin_oe_o(sm_oe[0]), .fb_o(sm_fb[0])
    );

    pla_out_macrocell #(.NUM_DT(NUM_DT)) u_sm1 (
        .por_i(por), .data_terms_i(sm_dt1), .clk_term_i(sm_clk),
        .set_term_i(1'b0), .rst_term_i(1'b0), .oe_term_i(1'b1),
        .ext_oe_n_i(sm_ext_oe_n), .preload_n_i(sm_preload_n), .pin_in_i(sm_pin[1]),
        .cfg_bypass_i(1'b0), .cfg_invert_i(1'b0),
        .pin_out_o(sm_out[1]), .pin_oe_o(sm_oe[1]), .fb_o(sm_fb[1])
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic pulse_main();
        @(posedge clk); clk_term = 1'b1;
        @(posedge clk); clk_term = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_sm();
        @(posedge clk); sm_clk = 1'b1;
        @(posedge clk); sm_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic exp_q;
        // R8: power-on state, both polarities
        settle();
        chk("R8 por clear active-high", {3'b0, pin_out}, 4'h0);
        @(posedge clk); invert = 1'b1;
        settle();
        chk("R8 por clear active-low", {3'b0, pin_out}, 4'h1);
        @(posedge clk); invert = 1'b0; por = 1'b0;
        settle();

        // R1 / R2 / R3 / R9: sweep the four mode/polarity combinations
        for (int m = 0; m < 4; m++) begin
            @(posedge clk);
            bypass = m[1];
            invert = m[0];
            set_t  = m[1];
            rst_t  = m[1];
            for (int d = 0; d < 16; d++) begin
                exp_q = (d != 0) ^ m[0];
                @(posedge clk); dt = d[3:0];
                if (m[1]) begin
                    settle();
                    chk("R2 bypass follows sum", {3'b0, pin_out}, {3'b0, exp_q});
                end else begin
                    pulse_main();
                    chk(m[0] ? "R3 registered inverted" : "R1 registered capture",
                        {3'b0, pin_out}, {3'b0, exp_q});
                    @(posedge clk); dt = (d != 0) ? 4'h0 : 4'hF;
                    settle();
                    chk("R9 no edge no change", {3'b0, pin_out}, {3'b0, exp_q});
                end
            end
        end
        @(posedge clk); bypass = 1'b0; invert = 1'b0; set_t = 1'b0; rst_t = 1'b0;
        @(posedge clk); dt = 4'h2;
        pulse_main();
        chk("R1 capture one term", {3'b0, pin_out}, 4'h1);
        @(posedge clk); invert = 1'b1;
        settle();
        chk("R3 invert flips pin", {3'b0, pin_out}, 4'h0);
        @(posedge clk); invert = 1'b0;
        settle();
        chk("R3 invert restored", {3'b0, pin_out}, 4'h1);

        // R4 / R5: enable gating and feedback source, register holds 1
        for (int e = 0; e < 4; e++) begin
            for (int p = 0; p < 2; p++) begin
                @(posedge clk); oe_t = e[1]; ext_oe_n = e[0]; pin_in = p[0];
                settle();
                chk("R4 enable gating", {3'b0, pin_oe}, {3'b0, e[1] & ~e[0]});
                chk("R5 feedback source", {3'b0, fb},
                    {3'b0, (e[1] & ~e[0]) ? 1'b1 : p[0]});
            end
        end
        @(posedge clk); oe_t = 1'b1; ext_oe_n = 1'b0; pin_in = 1'b0;

        // R6: asynchronous set/reset and their priority
        @(posedge clk); rst_t = 1'b1;
        settle();
        chk("R6 reset clears", {3'b0, pin_out}, 4'h0);
        @(posedge clk); rst_t = 1'b0; set_t = 1'b1;
        settle();
        chk("R6 set sets", {3'b0, pin_out}, 4'h1);
        @(posedge clk); rst_t = 1'b1;
        settle();
        chk("R6 both high gives 0", {3'b0, pin_out}, 4'h0);
        @(posedge clk); dt = 4'hF;
        pulse_main();
        pulse_main();
        chk("R6 reset beats clock", {3'b0, pin_out}, 4'h0);
        @(posedge clk); rst_t = 1'b0; set_t = 1'b0;
        @(posedge clk); rst_t = 1'b1;
        @(posedge clk); set_t = 1'b1;
        settle();
        chk("R6 set under reset ignored", {3'b0, pin_out}, 4'h0);
        @(posedge clk); rst_t = 1'b0; set_t = 1'b0; dt = 4'h0;
        @(posedge clk); set_t = 1'b1;
        pulse_main();
        chk("R6 set beats clock data", {3'b0, pin_out}, 4'h1);
        @(posedge clk); set_t = 1'b0;

        // R7: preload of 0 and 1, priority over clock, retention
        @(posedge clk); pin_in = 1'b0;
        @(posedge clk); preload_n = 1'b0;
        settle();
        chk("R7 preload 0", {3'b0, pin_out}, 4'h0);
        @(posedge clk); preload_n = 1'b1;
        settle();
        chk("R7 preload 0 retained", {3'b0, pin_out}, 4'h0);
        @(posedge clk); pin_in = 1'b1;
        @(posedge clk); preload_n = 1'b0;
        settle();
        chk("R7 preload 1", {3'b0, pin_out}, 4'h1);
        @(posedge clk); dt = 4'h0;
        pulse_main();
        chk("R7 preload beats clock", {3'b0, pin_out}, 4'h1);
        @(posedge clk); preload_n = 1'b1;
        @(posedge clk); pin_in = 1'b0;
        settle();
        chk("R7 preload 1 retained", {3'b0, pin_out}, 4'h1);
        pulse_main();
        chk("R1 capture after preload", {3'b0, pin_out}, 4'h0);

        // R8: power-on reset beats preload
        @(posedge clk); pin_in = 1'b1; preload_n = 1'b0;
        settle();
        chk("R7 preload before por", {3'b0, pin_out}, 4'h1);
        @(posedge clk); por = 1'b1;
        settle();
        chk("R8 por beats preload", {3'b0, pin_out}, 4'h0);
        @(posedge clk); invert = 1'b1;
        settle();
        chk("R8 por active-low reads 1", {3'b0, pin_out}, 4'h1);
        @(posedge clk); invert = 1'b0; preload_n = 1'b1;
        @(posedge clk); por = 1'b0;
        settle();

        // R5: two-cell counter through feedback
        chk("R5 counter start", {2'b0, sm_out}, 4'h0);
        for (int k = 1; k <= 6; k++) begin
            pulse_sm();
            chk("R5 counter step", {2'b0, sm_out}, (k % 4));
        end
        // R7: preload the counter to 2, outputs off while loading
        @(posedge clk); sm_ext_oe_n = 1'b1; sm_pin = 2'b10;
        @(posedge clk); sm_preload_n = 1'b0;
        @(posedge clk); sm_preload_n = 1'b1;
        @(posedge clk); sm_ext_oe_n = 1'b0;
        settle();
        chk("R7 counter preload", {2'b0, sm_out}, 4'h2);
        pulse_sm();
        chk("R5 counter after preload", {2'b0, sm_out}, 4'h3);
        pulse_sm();
        chk("R5 counter wraps", {2'b0, sm_out}, 4'h0);

        finish_run();
    end

endmodule